// File: doc/BRIEF.md
# Audio Serial Port Status and Interrupt Controller

This block collects the events of a full-duplex audio serial port into one status word and drives a single interrupt line. Single-cycle pulses from the serializer and the FIFOs set sticky flags. The flags stay set until software writes ones to a separate clear register. The low bits and the top bits of the status word are not stored. They follow the FIFO fill state every cycle, so the clear register cannot reach them.

Software uses a small register port with a two-bit address. Address 0 returns the status word and ignores writes. Address 1 holds the interrupt-enable mask. Address 2 is the write-one-to-clear register and always reads as zero. Reads are combinational from the address. Writes take effect on the rising clock edge. A separate input tells the block whether the port runs as a clock slave. Frame errors are only recorded in that mode.

Top module: `aport_irq_status`

## Requirements
- R1: After a synchronous reset every sticky flag and every enable bit reads zero, and `irq` is low.
- R2: A one-cycle pulse on an event input sets its status bit from the next cycle onward, and the bit then holds without further pulses. The bit positions are: transfer end 3, TX filled 4, underrun 5, overrun 6, CRC error 7, frame error 8, mode fault 9, reload accepted 10, suspend 11.
- R3: Writing a one to bit n (3 to 11) at address 2 clears sticky flag n in the next cycle. Flags whose bit is written as zero keep their value.
- R4: Clear-register bits 0 to 2 and 12 to 15 have no effect. Neither the level bits nor any sticky flag change because of them.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the flag ends up set.
- R6: A frame-error pulse is ignored while `slave_mode` is low. It sets bit 8 only while `slave_mode` is high.
- R7: The level bits follow the FIFO inputs in the same cycle: RX packet at bit 0, TX space at bit 1, both-ready at bit 2 (the AND of bits 0 and 1), TX complete at bit 12, RX level at bits 14:13, RX word pending at bit 15.
- R8: Address 1 stores the enable mask in bits 10:0. Bits 15:11 read as zero.
- R9: `irq` is high exactly when some status bit 0 to 10 and its enable bit are both one.
- R10: Address 2 reads as zero at all times, and writes to address 0 leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 clear |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| slave_mode | input | 1 | High when the port is a clock slave |
| ev_xfer_end | input | 1 | Transfer-end pulse |
| ev_tx_filled | input | 1 | TX transfer-filled pulse |
| ev_underrun | input | 1 | TX underrun pulse |
| ev_overrun | input | 1 | RX overrun pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_frame_err | input | 1 | Frame error pulse |
| ev_mode_fault | input | 1 | Mode fault pulse |
| ev_reload | input | 1 | Reload-accepted pulse |
| ev_suspend | input | 1 | Suspend pulse |
| fifo_rx_pkt | input | 1 | RX FIFO holds a packet |
| fifo_tx_space | input | 1 | TX FIFO has room for a packet |
| fifo_tx_done | input | 1 | TX side complete |
| fifo_rx_level | input | 2 | RX FIFO frame level |
| fifo_rx_word_pending | input | 1 | RX word not yet read |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall on the same edge: an event pulse setting a sticky flag, and a software clear of that same flag. The bench drives an overrun pulse in the same cycle as a clear write that names the overrun bit. The same write also names an underrun flag that is already set. It then reads the status and expects the overrun bit still set and the underrun bit cleared. A second case pairs a clear write with a frame-error pulse while the port is not a slave. Both must leave the flag at zero.

// File: rtl/aport_pkg.sv
package aport_pkg;

    localparam int STAT_W   = 16;
    localparam int IEN_W    = 11;
    localparam int STICKY_LO = 3;
    localparam int STICKY_HI = 11;

    localparam int B_RXRDY   = 0;
    localparam int B_TXRDY   = 1;
    localparam int B_DUPRDY  = 2;
    localparam int B_XEND    = 3;
    localparam int B_TXFILL  = 4;
    localparam int B_UNDER   = 5;
    localparam int B_OVER    = 6;
    localparam int B_CRC     = 7;
    localparam int B_FRAME   = 8;
    localparam int B_MODE    = 9;
    localparam int B_RELOAD  = 10;
    localparam int B_SUSP    = 11;
    localparam int B_TXDONE  = 12;
    localparam int B_RXLVL_L = 13;
    localparam int B_RXWNE   = 15;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       rx_pkt;
        logic       tx_space;
        logic       tx_done;
        logic [1:0] rx_level;
        logic       rx_wne;
    } fifo_view_t;

    function automatic logic [STAT_W-1:0] level_bits(input fifo_view_t v);
        logic [STAT_W-1:0] s;
        s = '0;
        s[B_RXRDY]                 = v.rx_pkt;
        s[B_TXRDY]                 = v.tx_space;
        s[B_DUPRDY]                = v.rx_pkt & v.tx_space;
        s[B_TXDONE]                = v.tx_done;
        s[B_RXLVL_L+1:B_RXLVL_L]   = v.rx_level;
        s[B_RXWNE]                 = v.rx_wne;
        return s;
    endfunction

endpackage

// File: rtl/aport_sticky_flags.sv
module aport_sticky_flags #(
    parameter int LO = 3,
    parameter int HI = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HI:LO]  ev_set,
    input  logic [HI:LO]  clr_req,
    output logic [HI:LO]  flags
);

    generate
        for (genvar i = LO; i <= HI; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    flags[i] <= 1'b0;
                else if (ev_set[i])
                    flags[i] <= 1'b1;
                else if (clr_req[i])
                    flags[i] <= 1'b0;
            end
        end
    endgenerate

    // R5: a pulse wins over a clear in the same cycle
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|ev_set) |=> ((flags & $past(ev_set)) == $past(ev_set)));

    // R3: a clear without a concurrent pulse takes effect
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (|(clr_req & ~ev_set)) |=> ((flags & $past(clr_req & ~ev_set)) == '0));

    // R2: flags hold when nothing touches them
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (ev_set == '0 && clr_req == '0) |=> $stable(flags));

endmodule

// File: rtl/aport_enable_reg.sv
module aport_enable_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ien
);

    always_ff @(posedge clk) begin
        if (rst)
            ien <= '0;
        else if (wr)
            ien <= wdata;
    end

    // R8: a write lands in the mask
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ien == $past(wdata)));

endmodule

// File: rtl/aport_irq_merge.sv
module aport_irq_merge #(
    parameter int W = 11
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] ien,
    output logic         irq
);

    logic [W-1:0] hits;

    generate
        for (genvar i = 0; i < W; i++) begin : g_hit
            assign hits[i] = status[i] & ien[i];
        end
    endgenerate

    assign irq = |hits;

endmodule

// File: rtl/aport_irq_status.sv
module aport_irq_status
    import aport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        slave_mode,
    input  logic        ev_xfer_end,
    input  logic        ev_tx_filled,
    input  logic        ev_underrun,
    input  logic        ev_overrun,
    input  logic        ev_crc_err,
    input  logic        ev_frame_err,
    input  logic        ev_mode_fault,
    input  logic        ev_reload,
    input  logic        ev_suspend,
    input  logic        fifo_rx_pkt,
    input  logic        fifo_tx_space,
    input  logic        fifo_tx_done,
    input  logic [1:0]  fifo_rx_level,
    input  logic        fifo_rx_word_pending,
    output logic        irq
);

    reg_sel_e                   sel;
    fifo_view_t                 view;
    logic [STICKY_HI:STICKY_LO] ev_set;
    logic [STICKY_HI:STICKY_LO] clr_req;
    logic [STICKY_HI:STICKY_LO] flags;
    logic [IEN_W-1:0]           ien;
    logic [STAT_W-1:0]          status;
    logic                       ien_wr;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        ev_set           = '0;
        ev_set[B_XEND]   = ev_xfer_end;
        ev_set[B_TXFILL] = ev_tx_filled;
        ev_set[B_UNDER]  = ev_underrun;
        ev_set[B_OVER]   = ev_overrun;
        ev_set[B_CRC]    = ev_crc_err;
        ev_set[B_FRAME]  = ev_frame_err & slave_mode;
        ev_set[B_MODE]   = ev_mode_fault;
        ev_set[B_RELOAD] = ev_reload;
        ev_set[B_SUSP]   = ev_suspend;
    end

    assign clr_req = (reg_wr && sel == SEL_CLEAR) ? reg_wdata[STICKY_HI:STICKY_LO] : '0;
    assign ien_wr  = reg_wr && sel == SEL_ENABLE;

    assign view.rx_pkt   = fifo_rx_pkt;
    assign view.tx_space = fifo_tx_space;
    assign view.tx_done  = fifo_tx_done;
    assign view.rx_level = fifo_rx_level;
    assign view.rx_wne   = fifo_rx_word_pending;

    aport_sticky_flags #(.LO(STICKY_LO), .HI(STICKY_HI)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .ev_set  (ev_set),
        .clr_req (clr_req),
        .flags   (flags)
    );

    aport_enable_reg #(.W(IEN_W)) u_ien (
        .clk   (clk),
        .rst   (rst),
        .wr    (ien_wr),
        .wdata (reg_wdata[IEN_W-1:0]),
        .ien   (ien)
    );

    always_comb begin
        status = level_bits(view);
        status[STICKY_HI:STICKY_LO] = flags;
    end

    aport_irq_merge #(.W(IEN_W)) u_irq (
        .status (status[IEN_W-1:0]),
        .ien    (ien),
        .irq    (irq)
    );

    always_comb begin
        case (sel)
            SEL_STATUS: reg_rdata = status;
            SEL_ENABLE: reg_rdata = {{(STAT_W-IEN_W){1'b0}}, ien};
            default:    reg_rdata = '0;
        endcase
    end

    // R6: frame error cannot latch outside slave mode
    a_r6_frame_needs_slave: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !flags[B_FRAME]) |=> !flags[B_FRAME]);

    // R9: interrupt follows masked status
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        ((status[IEN_W-1:0] & ien) == '0) |-> !irq);
    a_r9_irq_raised: assert property (@(posedge clk) disable iff (rst)
        ((status[IEN_W-1:0] & ien) != '0) |-> irq);

    // R10: clear register reads back as zero
    a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == SEL_CLEAR) |-> (reg_rdata == '0));

    // R8: upper enable bits read zero
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == SEL_ENABLE) |-> (reg_rdata[STAT_W-1:IEN_W] == '0));

endmodule

// File: tb/sim_aport_irq_status.sv
module sim_aport_irq_status;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        slave_mode;
    logic        ev_xfer_end, ev_tx_filled, ev_underrun, ev_overrun, ev_crc_err;
    logic        ev_frame_err, ev_mode_fault, ev_reload, ev_suspend;
    logic        fifo_rx_pkt, fifo_tx_space, fifo_tx_done, fifo_rx_word_pending;
    logic [1:0]  fifo_rx_level;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aport_irq_status u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slave_mode(slave_mode),
        .ev_xfer_end(ev_xfer_end), .ev_tx_filled(ev_tx_filled),
        .ev_underrun(ev_underrun), .ev_overrun(ev_overrun),
        .ev_crc_err(ev_crc_err), .ev_frame_err(ev_frame_err),
        .ev_mode_fault(ev_mode_fault), .ev_reload(ev_reload),
        .ev_suspend(ev_suspend), .fifo_rx_pkt(fifo_rx_pkt),
        .fifo_tx_space(fifo_tx_space), .fifo_tx_done(fifo_tx_done),
        .fifo_rx_level(fifo_rx_level),
        .fifo_rx_word_pending(fifo_rx_word_pending), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic clear_events();
        {ev_xfer_end, ev_tx_filled, ev_underrun, ev_overrun, ev_crc_err,
         ev_frame_err, ev_mode_fault, ev_reload, ev_suspend} = '0;
    endtask

    task automatic set_event(input int bitpos);
        case (bitpos)
            3:  ev_xfer_end   = 1'b1;
            4:  ev_tx_filled  = 1'b1;
            5:  ev_underrun   = 1'b1;
            6:  ev_overrun    = 1'b1;
            7:  ev_crc_err    = 1'b1;
            8:  ev_frame_err  = 1'b1;
            9:  ev_mode_fault = 1'b1;
            10: ev_reload     = 1'b1;
            11: ev_suspend    = 1'b1;
            default: ;
        endcase
    endtask

    task automatic pulse(input int bitpos);
        @(negedge clk);
        set_event(bitpos);
        @(negedge clk);
        clear_events();
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        reg_read(2'd0, v); check("R1 status after reset", v, 16'h0000);
        reg_read(2'd1, v); check("R1 enable after reset", v, 16'h0000);
        check("R1 irq after reset", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_levels();
        logic [15:0] v;
        @(negedge clk);
        fifo_rx_pkt = 1; fifo_tx_space = 1; fifo_tx_done = 1;
        fifo_rx_level = 2'b10; fifo_rx_word_pending = 1;
        reg_read(2'd0, v); check("R7 all levels", v, 16'hD007);
        fifo_tx_space = 0; fifo_tx_done = 0; fifo_rx_level = 2'b01; fifo_rx_word_pending = 0;
        reg_read(2'd0, v); check("R7 rx only", v, 16'h2001);
        fifo_rx_pkt = 0; fifo_rx_level = 2'b00;
        reg_read(2'd0, v); check("R7 idle", v, 16'h0000);
    endtask

    task automatic t_events();
        logic [15:0] v;
        logic [15:0] exp;
        slave_mode = 1;
        exp = 16'h0000;
        for (int b = 3; b <= 11; b++) begin
            pulse(b);
            exp[b] = 1'b1;
            reg_read(2'd0, v); check($sformatf("R2 set bit %0d", b), v, exp);
        end
        repeat (3) @(negedge clk);
        reg_read(2'd0, v); check("R2 flags hold", v, 16'h0FF8);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        @(negedge clk); fifo_rx_pkt = 1;
        reg_write(2'd2, 16'hF007);
        reg_read(2'd0, v); check("R4 outside bits ignored", v, 16'h0FF9);
        reg_write(2'd2, 16'h0020);
        reg_read(2'd0, v); check("R3 clear underrun only", v, 16'h0FD9);
        reg_write(2'd0, 16'hFFFF);
        reg_read(2'd0, v); check("R10 status write ignored", v, 16'h0FD9);
        reg_write(2'd2, 16'h0FF8);
        reg_read(2'd0, v); check("R3 clear all sticky", v, 16'h0001);
        @(negedge clk); fifo_rx_pkt = 0;
    endtask

    task automatic t_frame_mode();
        logic [15:0] v;
        slave_mode = 0;
        pulse(8);
        reg_read(2'd0, v); check("R6 frame ignored as master", v, 16'h0000);
        @(negedge clk);
        ev_frame_err = 1; reg_addr = 2'd2; reg_wdata = 16'h0100; reg_wr = 1;
        @(negedge clk);
        clear_events(); reg_wr = 0;
        reg_read(2'd0, v); check("R6 frame with clear as master", v, 16'h0000);
        slave_mode = 1;
        pulse(8);
        reg_read(2'd0, v); check("R6 frame latched as slave", v, 16'h0100);
        reg_write(2'd2, 16'h0100);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        pulse(5);
        @(negedge clk);
        ev_overrun = 1; reg_addr = 2'd2; reg_wdata = 16'h0060; reg_wr = 1;
        @(negedge clk);
        clear_events(); reg_wr = 0;
        reg_read(2'd0, v); check("R5 set wins over clear", v, 16'h0040);
        reg_write(2'd2, 16'h0040);
        reg_read(2'd0, v); check("R3 later clear", v, 16'h0000);
    endtask

    task automatic t_enable_irq();
        logic [15:0] v;
        reg_write(2'd1, 16'hFFFF);
        reg_read(2'd1, v); check("R8 enable readback", v, 16'h07FF);
        check("R9 no irq with no flags", {15'd0, irq}, 16'h0000);
        @(negedge clk); fifo_rx_pkt = 1; #1;
        check("R9 irq from level bit", {15'd0, irq}, 16'h0001);
        @(negedge clk); fifo_rx_pkt = 0;
        reg_write(2'd1, 16'h0040);
        pulse(5);
        check("R9 masked underrun no irq", {15'd0, irq}, 16'h0000);
        pulse(6);
        check("R9 enabled overrun irq", {15'd0, irq}, 16'h0001);
        pulse(11);
        reg_write(2'd2, 16'h0040);
        check("R9 irq drops after clear", {15'd0, irq}, 16'h0000);
        reg_read(2'd0, v); check("R3 others kept", v, 16'h0820);
        reg_write(2'd1, 16'h0800);
        check("R9 bit 11 not maskable", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_clear_read();
        logic [15:0] v;
        reg_write(2'd2, 16'hABCD);
        reg_read(2'd2, v); check("R10 clear reads zero", v, 16'h0000);
        reg_read(2'd3, v); check("R10 spare reads zero", v, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; reg_addr = 0; reg_wr = 0; reg_wdata = 0; slave_mode = 0;
        clear_events();
        fifo_rx_pkt = 0; fifo_tx_space = 0; fifo_tx_done = 0;
        fifo_rx_level = 0; fifo_rx_word_pending = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_levels();
        t_events();
        t_clear();
        t_frame_mode();
        t_set_wins();
        t_enable_irq();
        t_clear_read();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule